// File: doc/BRIEF.md
# Recursive Karatsuba Carry-Less Multiplier

This block multiplies two binary polynomials of a configurable width `WIDTH` and returns their full carry-less product. Coefficients live in GF(2): sums are XOR and coefficient products are AND. The result has `2*WIDTH-1` bits, and no modular reduction is applied. The block is purely combinational, with no clock, no registers and no handshake. It is meant to sit inside a wider datapath, for example ahead of a reduction stage in a binary-field arithmetic unit.

Each operand is split into a high part and a low part. The low part has `floor(W/2)` bits and the high part has `ceil(W/2)` bits. Three half-size products are formed: high times high, low times low, and the XOR-sum of the halves multiplied together. These three products are merged with XOR at offsets `2*lo` and `lo`. Each half-size product is built the same way, recursively, down to a single AND gate. For odd widths the low half is zero-extended to the width of the high half before the sum is taken. This makes any width legal, not only powers of two.

Top module: `kara_clmul`

## Requirements
- R1: Output bit 0 equals `op_a[0] & op_b[0]`, and output bit `2*WIDTH-2` equals `op_a[WIDTH-1] & op_b[WIDTH-1]`.
- R2: For every operand pair, `prod` equals the carry-less product: bit k is the XOR over all i+j=k of `op_a[i] & op_b[j]`.
- R3: R2 holds for odd widths, where the halves are unequal (checked at widths 5 and 13).
- R4: If either operand is all zeros, `prod` is all zeros.
- R5: If `op_b` equals 1 (only bit 0 set), `prod` equals `op_a` zero-extended. If `op_a` equals 1, `prod` equals `op_b` zero-extended.
- R6: If `op_b` has only bit k set, `prod` equals `op_a` shifted left by k places.
- R7: Swapping the two operands leaves `prod` unchanged.
- R8: The product distributes over XOR: `mul(a, b^c) == mul(a,b) ^ mul(a,c)`.
- R9: Squaring spreads the bits. If `op_a == op_b`, then `prod[2i] = op_a[i]` and every odd bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First polynomial operand; bit i is the coefficient of x^i |
| op_b | input | WIDTH | Second polynomial operand |
| prod | output | 2*WIDTH-1 | Unreduced carry-less product |

## Verification
The two effects that can land on the same output column are the high product shifted by `2*lo` and the middle cross term shifted by `lo`. When the width is odd, these overlap unevenly. Operands with dense high bits provoke this: all-ones values, widths 5 and 13, and the exhaustive sweeps at widths 5 and 6. Each result is judged against a bit-serial shift-and-XOR reference that never splits the operands.

// File: rtl/kara_pkg.sv
package kara_pkg;
  // width of the lower half of a split operand
  function automatic int lo_part(input int w);
    return w / 2;
  endfunction

  // width of the upper half (takes the odd bit)
  function automatic int hi_part(input int w);
    return w - (w / 2);
  endfunction

  // number of AND gates in a recursive tree of width w
  function automatic int and_gates(input int w);
    if (w <= 1) return 1;
    return 2 * and_gates(hi_part(w)) + and_gates(lo_part(w));
  endfunction
endpackage

// File: rtl/kara_leaf.sv
module kara_leaf (
  input  logic a,
  input  logic b,
  output logic p
);
  assign p = a & b;
endmodule

// File: rtl/kara_combine.sv
module kara_combine #(
  parameter int W  = 4,
  parameter int LO = 2
) (
  input  logic [2*(W-LO)-2:0] t_hi,
  input  logic [2*(W-LO)-2:0] t_mid,
  input  logic [2*LO-2:0]     t_lo,
  output logic [2*W-2:0]      p
);
  localparam int HI = W - LO;
  localparam int HW = 2*HI - 1;
  localparam int PW = 2*W - 1;

  logic [HW-1:0] cross_term;
  logic [PW-1:0] hi_shifted, mid_shifted, lo_ext;

  always_comb begin
    cross_term  = t_hi ^ t_mid ^ HW'(t_lo);
    hi_shifted  = PW'(t_hi) << (2*LO);
    mid_shifted = PW'(cross_term) << LO;
    lo_ext      = PW'(t_lo);
    p           = hi_shifted ^ mid_shifted ^ lo_ext;
  end
endmodule

// File: rtl/kara_node.sv
module kara_node #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  generate
    if (W == 1) begin : g_leaf
      kara_leaf u_leaf (.a(a[0]), .b(b[0]), .p(p[0]));
    end else begin : g_split
      localparam int LO = kara_pkg::lo_part(W);
      localparam int HI = kara_pkg::hi_part(W);

      logic [HI-1:0]   a_hi, b_hi, a_sum, b_sum;
      logic [LO-1:0]   a_lo, b_lo;
      logic [2*HI-2:0] t_hi, t_mid;
      logic [2*LO-2:0] t_lo;

      assign a_hi  = a[W-1:LO];
      assign b_hi  = b[W-1:LO];
      assign a_lo  = a[LO-1:0];
      assign b_lo  = b[LO-1:0];
      assign a_sum = a_hi ^ HI'(a_lo);
      assign b_sum = b_hi ^ HI'(b_lo);

      kara_node #(.W(HI)) u_hi  (.a(a_hi),  .b(b_hi),  .p(t_hi));
      kara_node #(.W(HI)) u_mid (.a(a_sum), .b(b_sum), .p(t_mid));
      kara_node #(.W(LO)) u_lo  (.a(a_lo),  .b(b_lo),  .p(t_lo));

      kara_combine #(.W(W), .LO(LO)) u_comb (
        .t_hi (t_hi),
        .t_mid(t_mid),
        .t_lo (t_lo),
        .p    (p)
      );
    end
  endgenerate
endmodule

// File: rtl/kara_clmul.sv
module kara_clmul #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-2:0] prod
);
  localparam int AND_COUNT = kara_pkg::and_gates(WIDTH);

  // named event used by the checker: an operand with no set coefficient
  logic any_zero;
  assign any_zero = (op_a == '0) || (op_b == '0);

  kara_node #(.W(WIDTH)) u_root (.a(op_a), .b(op_b), .p(prod));

  initial begin
    if (AND_COUNT < WIDTH) $display("kara_clmul: unexpected tree size");
  end
endmodule

// File: rtl/kara_clmul_chk.sv
module kara_clmul_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic [2*WIDTH-2:0] prod,
  input logic               any_zero
);
  localparam int PW = 2*WIDTH - 1;
  logic [PW-1:0] sq_spread;

  always_comb begin
    sq_spread = '0;
    for (int i = 0; i < WIDTH; i++) sq_spread[2*i] = op_a[i];
  end

  always_comb begin
    // R1
    lsb_and_chk: assert (prod[0] == (op_a[0] & op_b[0]));
    // R1
    msb_and_chk: assert (prod[PW-1] == (op_a[WIDTH-1] & op_b[WIDTH-1]));
    // R4
    zero_in_chk: assert (!any_zero || prod == '0);
    // R5
    unit_b_chk: assert (op_b != WIDTH'(1) || prod == PW'(op_a));
    // R9
    square_chk: assert (op_a != op_b || prod == sq_spread);
  end
endmodule

bind kara_clmul kara_clmul_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .prod    (prod),
  .any_zero(any_zero)
);

// File: tb/kara_clmul_tb.sv
module kara_clmul_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] a16, b16;  logic [30:0] p16;
  logic [4:0]  a5,  b5;   logic [8:0]  p5;
  logic [5:0]  a6,  b6;   logic [10:0] p6;
  logic [12:0] a13, b13;  logic [24:0] p13;

  kara_clmul #(.WIDTH(16)) u_dut (.op_a(a16), .op_b(b16), .prod(p16));
  kara_clmul #(.WIDTH(5))  u_w5  (.op_a(a5),  .op_b(b5),  .prod(p5));
  kara_clmul #(.WIDTH(6))  u_w6  (.op_a(a6),  .op_b(b6),  .prod(p6));
  kara_clmul #(.WIDTH(13)) u_w13 (.op_a(a13), .op_b(b13), .prod(p13));

  // bit-serial shift-and-XOR reference
  function automatic logic [63:0] ref_clmul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] acc = '0;
    for (int i = 0; i < 32; i++)
      if (b[i]) acc = acc ^ (64'(a) << i);
    return acc;
  endfunction

  function automatic logic [63:0] ref_square(input logic [31:0] a);
    logic [63:0] s = '0;
    for (int i = 0; i < 32; i++) s[2*i] = a[i];
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    a16 = a; b16 = b;
    #1;
  endtask

  initial begin
    logic [30:0] first;
    logic [31:0] ra, rb, rc;
    logic [30:0] pab, pac;
    int seed;
    seed = $urandom(32'h1357_2468);
    a16 = '0; b16 = '0; a5 = '0; b5 = '0; a6 = '0; b6 = '0; a13 = '0; b13 = '0;
    #1;
    // R4 idle state with zero inputs
    check("R4 initial", 64'(p16), 64'd0);

    // R2 exhaustive width 6, R3 exhaustive width 5
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++) begin
        @(negedge clk);
        a6 = 6'(x); b6 = 6'(y);
        a5 = 5'(x); b5 = 5'(y);
        #1;
        check("R2 w6", 64'(p6), ref_clmul(32'(x & 63), 32'(y & 63)));
        if (x < 32 && y < 32) check("R3 w5", 64'(p5), ref_clmul(32'(x), 32'(y)));
      end

    // R3 random width 13 plus all-ones corner
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      ra = $urandom; rb = $urandom;
      a13 = ra[12:0]; b13 = rb[12:0];
      #1;
      check("R3 w13", 64'(p13), ref_clmul(32'(ra[12:0]), 32'(rb[12:0])));
    end
    @(negedge clk); a13 = '1; b13 = '1; #1;
    check("R3 w13 ones", 64'(p13), ref_clmul(32'h1FFF, 32'h1FFF));

    // R2 random width 16 plus dense corners
    for (int k = 0; k < 400; k++) begin
      ra = $urandom; rb = $urandom;
      drive16(ra[15:0], rb[15:0]);
      check("R2 w16", 64'(p16), ref_clmul(32'(ra[15:0]), 32'(rb[15:0])));
    end
    drive16(16'hFFFF, 16'hFFFF);
    check("R2 ones", 64'(p16), ref_clmul(32'hFFFF, 32'hFFFF));
    drive16(16'h8001, 16'hAAAA);
    check("R2 sparse", 64'(p16), ref_clmul(32'h8001, 32'hAAAA));

    // R1 end bits
    drive16(16'h8001, 16'h8001);
    check("R1 lsb", 64'(p16[0]), 64'd1);
    check("R1 msb", 64'(p16[30]), 64'd1);
    drive16(16'h7FFE, 16'hFFFF);
    check("R1 lsb clr", 64'(p16[0]), 64'd0);
    check("R1 msb clr", 64'(p16[30]), 64'd0);

    // R4 zero operands
    drive16(16'h0000, 16'hBEEF);
    check("R4 a zero", 64'(p16), 64'd0);
    drive16(16'hC0DE, 16'h0000);
    check("R4 b zero", 64'(p16), 64'd0);

    // R5 unit operand
    drive16(16'hA5C3, 16'h0001);
    check("R5 b one", 64'(p16), 64'h0000_0000_0000_A5C3);
    drive16(16'h0001, 16'h3C5A);
    check("R5 a one", 64'(p16), 64'h0000_0000_0000_3C5A);

    // R6 monomial multiplier shifts
    for (int k = 0; k < 16; k++) begin
      drive16(16'hD00B, 16'(1) << k);
      check("R6 shift", 64'(p16), 64'h0000_0000_0000_D00B << k);
    end

    // R7 operand swap
    for (int k = 0; k < 50; k++) begin
      ra = $urandom; rb = $urandom;
      drive16(ra[15:0], rb[15:0]);
      first = p16;
      drive16(rb[15:0], ra[15:0]);
      check("R7 swap", 64'(p16), 64'(first));
    end

    // R8 distributivity over XOR
    for (int k = 0; k < 50; k++) begin
      ra = $urandom; rb = $urandom; rc = $urandom;
      drive16(ra[15:0], rb[15:0]); pab = p16;
      drive16(ra[15:0], rc[15:0]); pac = p16;
      drive16(ra[15:0], rb[15:0] ^ rc[15:0]);
      check("R8 distrib", 64'(p16), 64'(pab ^ pac));
    end

    // R9 squaring
    for (int k = 0; k < 50; k++) begin
      ra = $urandom;
      drive16(ra[15:0], ra[15:0]);
      check("R9 square", 64'(p16), ref_square(32'(ra[15:0])));
    end
    drive16(16'hFFFF, 16'hFFFF);
    check("R9 square ones", 64'(p16), 64'h0000_0000_5555_5555 & 64'h7FFF_FFFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule